// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of already-synchronized input pins and turns activity on them into interrupt status. Every pin has its own detection mode. It can sense a level, either high or low. It can sense a single edge, either rising or falling. It can also sense any change of the pin. The mode is held in three per-pin configuration registers: a sense-kind register, a dual-edge register and a polarity register. A fourth register gates which pins may reach the interrupt line.

Two status views can be read back. The raw status shows what each detector has found, whatever the enable settings are. The masked status is the raw status with disabled pins removed. Edge detections stay latched until software writes a one to the matching bit of the clear register. Level detections simply track the pin. All masked bits are ORed into a single registered interrupt output.

Address decoding of the surrounding bus is done outside the block. The block receives a 3-bit register index, which is bits [4:2] of the register's byte offset. It also receives a write strobe, write data and a read index. It returns read data registered one cycle later.

Top module: `gpio_irq_top`

## Requirements
- R1: After synchronous reset, every configuration register, the raw status, the masked status, the read data and the interrupt output are all zero.
- R2: The register index selects the register. Index 1 is sense kind (1 = level, 0 = edge), index 2 is dual-edge, index 3 is polarity (1 = high/rising, 0 = low/falling) and index 4 is enable. Each of these four reads back the last value written to it. Read data appears one clock after the read index is presented.
- R3: A level-sensed pin with polarity 1 shows raw status 1 exactly while the pin is high, updated on the clock after the pin changes.
- R4: A level-sensed pin with polarity 0 shows raw status 1 exactly while the pin is low.
- R5: An edge-sensed pin with dual-edge 0 and polarity 1 sets its raw bit on a 0-to-1 change of the pin. The bit stays set after the pin returns low.
- R6: An edge-sensed pin with dual-edge 0 and polarity 0 sets its raw bit on a 1-to-0 change of the pin. A 0-to-1 change leaves the bit clear.
- R7: An edge-sensed pin with dual-edge 1 sets its raw bit on either change of the pin, whatever its polarity bit holds.
- R8: Raw status (index 5) does not depend on enable. Masked status (index 6) equals raw AND enable.
- R9: The interrupt output is the OR of all masked status bits, registered one clock after the raw status.
- R10: Writing to index 7 clears each latched edge bit whose data bit is 1. Data bits of 0 leave their pins unchanged.
- R11: A clear write has no effect on a level-sensed pin whose active level is still present.
- R12: When an edge is detected on a pin in the same cycle as a clear write to that pin, the raw bit ends up set.
- R13: Writes to indices 0, 5 and 6 change nothing. Indices 0 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write (byte offset bits [4:2]) |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench targets the places where the detector modes interact. The first is a clear write that lands in the same cycle as a new edge: a design that let the clear win would lose that event. The second is a clear aimed at an active level pin: a design that latched level events would show the bit dropping. The third is a single-edge pin that sees the opposite transition: a polarity decoded backwards would flag it. The bench also checks dual-edge pins with their polarity bit set against them, and raw status read back while enable is off. A masked-only raw register would hide pending events there, and a decoder that ignored the dual-edge bit would miss one of the two directions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_NONE   = 3'd0,
    IDX_KIND   = 3'd1,
    IDX_DUAL   = 3'd2,
    IDX_POL    = 3'd3,
    IDX_ENA    = 3'd4,
    IDX_RAW    = 3'd5,
    IDX_MASKED = 3'd6,
    IDX_CLEAR  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PINS-1:0]  wr_data,
  output logic [PINS-1:0]  kind_q,
  output logic [PINS-1:0]  dual_q,
  output logic [PINS-1:0]  pol_q,
  output logic [PINS-1:0]  ena_q
);
  localparam int unsigned NREG = 4;

  logic [NREG-1:0] sel;
  logic [PINS-1:0] regs_q [NREG];

  // one select line per writable configuration register
  always_comb begin
    sel = '0;
    if (wr_en) begin
      unique case (reg_idx_e'(wr_idx))
        IDX_KIND: sel[0] = 1'b1;
        IDX_DUAL: sel[1] = 1'b1;
        IDX_POL:  sel[2] = 1'b1;
        IDX_ENA:  sel[3] = 1'b1;
        default:  sel    = '0;
      endcase
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[r] <= '0;
      end else if (sel[r]) begin
        regs_q[r] <= wr_data;
      end
    end
  end

  assign kind_q = regs_q[0];
  assign dual_q = regs_q[1];
  assign pol_q  = regs_q[2];
  assign ena_q  = regs_q[3];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] kind,
  input  logic [PINS-1:0] dual,
  input  logic [PINS-1:0] pol,
  input  logic [PINS-1:0] clr,
  output logic [PINS-1:0] pin_prev,
  output logic [PINS-1:0] raw_q
);
  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev <= '0;
    end else begin
      pin_prev <= pin_in;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      rise[i] = pin_in[i] & ~pin_prev[i];
      fall[i] = ~pin_in[i] & pin_prev[i];
      if (dual[i]) begin
        hit[i] = rise[i] | fall[i];
      end else if (pol[i]) begin
        hit[i] = rise[i];
      end else begin
        hit[i] = fall[i];
      end
      lvl[i] = ~(pin_in[i] ^ pol[i]);
    end

    // level pins track the pin; edge pins latch, with a new edge beating a clear
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[i] <= 1'b0;
      end else if (kind[i]) begin
        raw_q[i] <= lvl[i];
      end else if (hit[i]) begin
        raw_q[i] <= 1'b1;
      end else if (clr[i]) begin
        raw_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PINS-1:0]  pin_in,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PINS-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PINS-1:0]  rd_data,
  output logic             irq
);
  logic [PINS-1:0] kind_q;
  logic [PINS-1:0] dual_q;
  logic [PINS-1:0] pol_q;
  logic [PINS-1:0] ena_q;
  logic [PINS-1:0] raw_q;
  logic [PINS-1:0] masked;
  logic [PINS-1:0] clr;
  logic [PINS-1:0] pin_prev;
  logic [PINS-1:0] rd_next;

  gpio_irq_cfg #(.PINS(PINS)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .kind_q  (kind_q),
    .dual_q  (dual_q),
    .pol_q   (pol_q),
    .ena_q   (ena_q)
  );

  assign clr = (wr_en && reg_idx_e'(wr_idx) == IDX_CLEAR) ? wr_data : '0;

  gpio_irq_detect #(.PINS(PINS)) u_det (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .kind     (kind_q),
    .dual     (dual_q),
    .pol      (pol_q),
    .clr      (clr),
    .pin_prev (pin_prev),
    .raw_q    (raw_q)
  );

  assign masked = raw_q & ena_q;

  always_comb begin
    unique case (reg_idx_e'(rd_idx))
      IDX_KIND:   rd_next = kind_q;
      IDX_DUAL:   rd_next = dual_q;
      IDX_POL:    rd_next = pol_q;
      IDX_ENA:    rd_next = ena_q;
      IDX_RAW:    rd_next = raw_q;
      IDX_MASKED: rd_next = masked;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_next;
      irq     <= |masked;
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [PINS-1:0]  pin_in,
  input logic [PINS-1:0]  pin_prev,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [PINS-1:0]  wr_data,
  input logic [PINS-1:0]  kind_q,
  input logic [PINS-1:0]  dual_q,
  input logic [PINS-1:0]  pol_q,
  input logic [PINS-1:0]  ena_q,
  input logic [PINS-1:0]  raw_q,
  input logic [PINS-1:0]  rd_data,
  input logic             irq
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_idx == IDX_CLEAR);

  // R1: reset leaves outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && rd_data == '0));

  // R9: interrupt is the registered OR of enabled raw bits
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(raw_q & ena_q))));

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    // R3, R4, R11: level pins follow the active level, clears ignored
    a_r11_level_follow: assert property (@(posedge clk) disable iff (rst)
      kind_q[i] |=> (raw_q[i] == $past(~(pin_in[i] ^ pol_q[i]))));

    // R5: a latched edge bit holds unless a clear hits it
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
      (!kind_q[i] && raw_q[i] && !(clr_wr && wr_data[i])) |=> raw_q[i]);

    // R7, R12: a dual-edge pin change always sets the bit, even under a clear
    a_r12_dual_change_sets: assert property (@(posedge clk) disable iff (rst)
      (!kind_q[i] && dual_q[i] && (pin_in[i] != pin_prev[i])) |=> raw_q[i]);
  end
endmodule

bind gpio_irq_top gpio_irq_chk #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_in   (pin_in),
  .pin_prev (pin_prev),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .kind_q   (kind_q),
  .dual_q   (dual_q),
  .pol_q    (pol_q),
  .ena_q    (ena_q),
  .raw_q    (raw_q),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/gpio_irq_top_test.sv
module gpio_irq_top_test;
  localparam int PINS = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PINS-1:0] pin_in = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_idx = '0;
  logic [PINS-1:0] wr_data = '0;
  logic [2:0]      rd_idx = '0;
  logic [PINS-1:0] rd_data;
  logic            irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  gpio_irq_top #(.PINS(PINS)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [PINS-1:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk_rd(input logic [2:0] idx, input logic [PINS-1:0] exp, input string req);
    rd_idx = idx;
    tick();
    n_checks++;
    if (rd_data !== exp) begin
      n_fails++;
      $display("FAIL %s: index %0d read %h expected %h", req, idx, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    n_checks++;
    if (irq !== exp) begin
      n_fails++;
      $display("FAIL %s: irq %b expected %b", req, irq, exp);
    end
  endtask

  task automatic clean();
    pin_in = '0;
    tick(); tick();
    wr(3'd1, '0); wr(3'd2, '0); wr(3'd3, '0); wr(3'd4, '0);
    wr(3'd7, '1);
    tick();
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) chk_rd(k[2:0], '0, "R1");
    chk_irq(1'b0, "R1");
  endtask

  task automatic t_regs();
    wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h81); wr(3'd4, 8'h00);
    chk_rd(3'd1, 8'hA5, "R2");
    chk_rd(3'd2, 8'h3C, "R2");
    chk_rd(3'd3, 8'h81, "R2");
    chk_rd(3'd4, 8'h00, "R2");
    clean();
    wr(3'd0, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    chk_rd(3'd0, 8'h00, "R13");
    chk_rd(3'd5, 8'h00, "R13");
    chk_rd(3'd6, 8'h00, "R13");
    chk_rd(3'd7, 8'h00, "R13");
    chk_rd(3'd1, 8'h00, "R13");
    chk_irq(1'b0, "R13");
  endtask

  task automatic t_level_high();
    wr(3'd1, 8'h01); wr(3'd3, 8'h01); wr(3'd4, 8'h01);
    chk_rd(3'd5, 8'h00, "R3");
    pin_in[0] = 1'b1;
    tick();
    chk_rd(3'd5, 8'h01, "R3");
    chk_irq(1'b1, "R9");
    wr(3'd7, 8'h01);
    chk_rd(3'd5, 8'h01, "R11");
    pin_in[0] = 1'b0;
    tick();
    chk_rd(3'd5, 8'h00, "R3");
    chk_irq(1'b0, "R9");
    clean();
  endtask

  task automatic t_level_low();
    wr(3'd1, 8'h02);
    tick();
    chk_rd(3'd5, 8'h02, "R4");
    pin_in[1] = 1'b1;
    tick();
    chk_rd(3'd5, 8'h00, "R4");
    clean();
  endtask

  task automatic t_rise();
    wr(3'd3, 8'h04);
    pin_in[2] = 1'b1; tick();
    pin_in[2] = 1'b0; tick();
    chk_rd(3'd5, 8'h04, "R5");
    chk_rd(3'd6, 8'h00, "R8");
    chk_irq(1'b0, "R8");
    wr(3'd4, 8'h04);
    chk_rd(3'd6, 8'h04, "R8");
    chk_irq(1'b1, "R9");
    wr(3'd7, 8'hFB);
    chk_rd(3'd5, 8'h04, "R10");
    wr(3'd7, 8'h04);
    chk_rd(3'd5, 8'h00, "R10");
    chk_irq(1'b0, "R10");
    clean();
  endtask

  task automatic t_fall();
    pin_in[3] = 1'b1; tick();
    chk_rd(3'd5, 8'h00, "R6");
    pin_in[3] = 1'b0; tick();
    chk_rd(3'd5, 8'h08, "R6");
    clean();
  endtask

  task automatic t_dual();
    wr(3'd2, 8'h10); wr(3'd3, 8'h10);
    pin_in[4] = 1'b1; tick();
    chk_rd(3'd5, 8'h10, "R7");
    wr(3'd7, 8'h10);
    chk_rd(3'd5, 8'h00, "R7");
    pin_in[4] = 1'b0; tick();
    chk_rd(3'd5, 8'h10, "R7");
    clean();
  endtask

  task automatic t_edge_wins();
    wr(3'd3, 8'h20); wr(3'd4, 8'hC0);
    pin_in[5] = 1'b1;
    wr(3'd7, 8'h20);
    chk_rd(3'd5, 8'h20, "R12");
    chk_irq(1'b0, "R8");
    clean();
  endtask

  task automatic t_multi();
    wr(3'd3, 8'hC0); wr(3'd4, 8'hC0);
    pin_in[7] = 1'b1; tick();
    chk_rd(3'd6, 8'h80, "R8");
    chk_irq(1'b1, "R9");
    pin_in[6] = 1'b1; tick();
    wr(3'd7, 8'h80);
    chk_rd(3'd6, 8'h40, "R10");
    chk_irq(1'b1, "R9");
    wr(3'd7, 8'h40);
    tick();
    chk_irq(1'b0, "R9");
    clean();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_dual();
    t_edge_wins();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule